// File: doc/BRIEF.md
# Program Counter with OR-Combined Jump Target

This block keeps the 16-bit address of the instruction being fetched from program ROM. It runs on one clock with two phase qualifiers. In the second phase it works out the address that comes next and holds it in a staging register. In the following first phase it moves that staged value onto the ROM address output. With no jump pending, the next address is the current one plus one. The increment is built as a toggle chain: bit 0 always flips, and each higher bit flips only when every bit below it is 1.

A jump is taken when the instruction decoder raises the jump strobe and the Skip bit is clear. The target comes from the instruction operand. When the zero-page flag is 1, the target is the 10-bit offset with zeros above it. When the flag is 0, the target is the 16-bit jump-destination value with the offset ORed into its low bits. An OR costs far less logic than an adder here. A halt input freezes both phases, so the address stays where it is.

Top module: `pc_or_jump`

## Requirements
- R1: `rom_addr` changes only on a clock edge where `ph1_en` is 1 and `halt` is 0. On such an edge it takes the value staged by the most recent second phase. The two phase qualifiers are never 1 in the same cycle.
- R2: In a second phase with no jump taken, the staged value is `rom_addr + 1`.
- R3: A jump is taken only when `jmp_strobe` is 1 and `skip` is 0. When `jmp_strobe` is 1 and `skip` is 1, the counter increments instead.
- R4: A taken jump with `zpage` = 0 stages `jdest | {6'b0, offset}`.
- R5: A taken jump with `zpage` = 1 stages `{6'b0, offset}`, and `jdest` has no effect.
- R6: While `halt` is 1, neither phase changes any state, so `rom_addr` holds its value.
- R7: While `rst_n` is 0, the staging register and `rom_addr` are both 0.
- R8: Incrementing from 0xFFFF gives 0x0000.
- R9: `jmp_strobe`, `skip`, `zpage`, `offset` and `jdest` are sampled only in cycles where `ph2_en` is 1. Their values in first-phase cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph1_en | input | 1 | First-phase qualifier: publish the staged address |
| ph2_en | input | 1 | Second-phase qualifier: compute and stage the next address |
| halt | input | 1 | Freeze both phases |
| jmp_strobe | input | 1 | Jump request from the instruction decoder |
| skip | input | 1 | Cancels a jump when 1 |
| zpage | input | 1 | 1 selects the raw offset as the target; 0 ORs the offset with `jdest` |
| offset | input | 10 | Instruction offset field |
| jdest | input | 16 | Jump-destination value |
| rom_addr | output | 16 | Current program ROM address |

## Verification
The bench drives the counter to 0xFFFF with an OR-combined jump and then increments it once. A design that sized or chained the toggle logic badly would land on a value other than zero. It raises the strobe together with Skip, and it also supplies a large `jdest` in zero-page mode. A gate that ignores Skip, or a mux that leaks `jdest`, would then produce a wrong address. It also toggles the jump inputs during first-phase cycles and holds halt across both phases. A design that sampled its inputs in the wrong phase, or published during halt, would move the address when it should not.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int unsigned PC_W  = 16;
  localparam int unsigned OFS_W = 10;

  // jump target: raw offset in zero-page mode, else destination ORed with offset
  function automatic logic [PC_W-1:0] jump_target(
    input logic             zp,
    input logic [OFS_W-1:0] ofs,
    input logic [PC_W-1:0]  dest
  );
    logic [PC_W-1:0] ext;
    ext = {{(PC_W-OFS_W){1'b0}}, ofs};
    return zp ? ext : (dest | ext);
  endfunction
endpackage

// File: rtl/pc_incr.sv
module pc_incr #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic [W-1:0] flip;

  assign flip[0] = 1'b1;
  genvar i;
  generate
    for (i = 1; i < W; i++) begin : g_chain
      assign flip[i] = flip[i-1] & cur[i-1];
    end
  endgenerate

  assign nxt = cur ^ flip;
endmodule

// File: rtl/pc_target.sv
module pc_target #(
  parameter int unsigned W     = 16,
  parameter int unsigned OFS_W = 10
) (
  input  logic             take_jump,
  input  logic             zp,
  input  logic [OFS_W-1:0] ofs,
  input  logic [W-1:0]     dest,
  input  logic [W-1:0]     seq_addr,
  output logic [W-1:0]     next_addr
);
  localparam int unsigned PAD_W = W - OFS_W;
  logic [W-1:0] ofs_ext;
  logic [W-1:0] tgt;

  assign ofs_ext = {{PAD_W{1'b0}}, ofs};

  always_comb begin
    if (zp) tgt = ofs_ext;
    else    tgt = dest | ofs_ext;
    next_addr = take_jump ? tgt : seq_addr;
  end
endmodule

// File: rtl/pc_stage.sv
module pc_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] cap_d,
  input  logic         xfer_en,
  output logic [W-1:0] stage_q,
  output logic [W-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      if (cap_en)  stage_q <= cap_d;
      if (xfer_en) out_q   <= stage_q;
    end
  end
endmodule

// File: rtl/pc_or_jump.sv
module pc_or_jump #(
  parameter int unsigned ADDR_W = pc_pkg::PC_W,
  parameter int unsigned OFS_W  = pc_pkg::OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph1_en,
  input  logic              ph2_en,
  input  logic              halt,
  input  logic              jmp_strobe,
  input  logic              skip,
  input  logic              zpage,
  input  logic [OFS_W-1:0]  offset,
  input  logic [ADDR_W-1:0] jdest,
  output logic [ADDR_W-1:0] rom_addr
);
  logic              take_jump;
  logic              cap_fire;
  logic              xfer_fire;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] next_addr;
  logic [ADDR_W-1:0] stage_q;

  assign take_jump = jmp_strobe & ~skip;
  assign cap_fire  = ph2_en & ~halt;
  assign xfer_fire = ph1_en & ~halt;

  pc_incr #(.W(ADDR_W)) u_incr (
    .cur (rom_addr),
    .nxt (seq_addr)
  );

  pc_target #(.W(ADDR_W), .OFS_W(OFS_W)) u_target (
    .take_jump (take_jump),
    .zp        (zpage),
    .ofs       (offset),
    .dest      (jdest),
    .seq_addr  (seq_addr),
    .next_addr (next_addr)
  );

  pc_stage #(.W(ADDR_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_fire),
    .cap_d   (next_addr),
    .xfer_en (xfer_fire),
    .stage_q (stage_q),
    .out_q   (rom_addr)
  );

  // phases never overlap
  assert_phase_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph1_en && ph2_en));

  assert_addr_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_fire |=> $stable(rom_addr));

  assert_addr_publish_R1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fire |=> rom_addr == $past(stage_q));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && !jmp_strobe) |=> stage_q == ADDR_W'($past(rom_addr) + 1'b1));

  assert_skip_cancel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && jmp_strobe && skip) |=> stage_q == ADDR_W'($past(rom_addr) + 1'b1));

  assert_zp_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && jmp_strobe && !skip && zpage) |=> stage_q == ADDR_W'($past(offset)));

  assert_or_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && jmp_strobe && !skip && !zpage)
      |=> stage_q == ($past(jdest) | ADDR_W'($past(offset))));

  assert_halt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> ($stable(rom_addr) && $stable(stage_q)));
endmodule

// File: tb/pc_or_jump_tb.sv
module pc_or_jump_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ph1_en, ph2_en, halt, jmp_strobe, skip, zpage;
  logic [9:0]  offset;
  logic [15:0] jdest;
  logic [15:0] rom_addr;

  int total = 0;
  int bad   = 0;

  logic [15:0] model_pc;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_or_jump u_dut (
    .clk(clk), .rst_n(rst_n), .ph1_en(ph1_en), .ph2_en(ph2_en), .halt(halt),
    .jmp_strobe(jmp_strobe), .skip(skip), .zpage(zpage), .offset(offset),
    .jdest(jdest), .rom_addr(rom_addr)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one instruction: a second-phase cycle followed by a first-phase cycle
  task automatic do_instr(input logic j, input logic s, input logic zp,
                          input logic [9:0] o, input logic [15:0] d,
                          input logic h, input logic noise, input string tag);
    logic [15:0] nxt;
    if (h) nxt = model_pc;
    else if (j && !s) nxt = zp ? {6'b0, o} : (d | {6'b0, o});
    else nxt = model_pc + 16'd1;
    model_pc = nxt;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
    ph2_en = 1'b1; ph1_en = 1'b0; halt = h;
    jmp_strobe = j; skip = s; zpage = zp; offset = o; jdest = d;
    @(negedge clk);
    ph2_en = 1'b0; ph1_en = 1'b1;
    if (noise) begin
      jmp_strobe = 1'b1; skip = 1'b0; zpage = 1'b1; offset = 10'h2A5; jdest = 16'hBEEF;
    end else begin
      jmp_strobe = 1'b0; skip = 1'b0; zpage = 1'b0; offset = '0; jdest = '0;
    end
    @(negedge clk);
    ph1_en = 1'b0;
  endtask

  // monitor: after each first-phase edge, compare against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      if (ph1_en) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R1: actual=%h expected=<none queued>", rom_addr);
        end else begin
          check(tag_q.pop_front(), rom_addr, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ph1_en = 0; ph2_en = 0; halt = 0; jmp_strobe = 0; skip = 0;
    zpage = 0; offset = '0; jdest = '0; model_pc = '0;
    repeat (3) @(negedge clk);
    check("R7 reset", rom_addr, 16'h0000);
    rst_n = 1'b1;

    for (int k = 0; k < 5; k++) do_instr(0, 0, 0, '0, '0, 0, 0, "R2 step");
    do_instr(1, 1, 1, 10'h123, 16'h0000, 0, 0, "R3 skip cancels");
    do_instr(0, 1, 0, '0, '0, 0, 0, "R3 skip alone");
    do_instr(1, 0, 1, 10'h3C7, 16'hFFFF, 0, 0, "R5 zero-page jump");
    do_instr(1, 0, 0, 10'h055, 16'hA300, 0, 0, "R4 or jump");
    do_instr(1, 0, 0, 10'h0F0, 16'h10FF, 0, 0, "R4 overlapping bits");
    do_instr(1, 0, 0, 10'h003, 16'hFFFC, 0, 0, "R4 reach top");
    do_instr(0, 0, 0, '0, '0, 0, 0, "R8 wrap");
    do_instr(0, 0, 0, '0, '0, 0, 0, "R2 after wrap");
    do_instr(1, 0, 1, 10'h1FF, 16'h0000, 1, 0, "R6 halt with jump");
    do_instr(0, 0, 0, '0, '0, 1, 0, "R6 halt hold");
    do_instr(0, 0, 0, '0, '0, 0, 0, "R6 resume");
    for (int k = 0; k < 3; k++) do_instr(0, 0, 0, '0, '0, 0, 1, "R9 ph1 noise");
    do_instr(0, 0, 0, '0, '0, 0, 0, "R1 publish");

    repeat (3) @(negedge clk);
    check("R1 no extra update", rom_addr, model_pc);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R1: actual=%0d expected=0 pending", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule